// File: doc/BRIEF.md
# PCM Sample Packer and Receive FIFO

This block sits behind a pair of audio decimation channels and turns their 16-bit PCM samples into 32-bit words held in a receive FIFO for a processor to read. A two-bit channel mode picks one channel or both. With packing off, each FIFO word carries one sign-extended sample. With packing on, two 16-bit samples share a word. In mono mode the pair is an older and a newer sample of the chosen channel. In stereo mode the pair is one left and one right sample, and a swap control sets which of the two comes first.

The processor reads the word at the head of the FIFO and pops it with a strobe. It sees the fill level and can flush the FIFO with a one-cycle pulse. Three sticky interrupt causes are kept: fill level above a programmable threshold, a push dropped because the FIFO was full, and a pop from an empty FIFO. Each cause has an enable bit and can be forced set or cleared. One interrupt line combines the enabled causes.

The sample strobe marks a new left/right sample pair. It never asserts on two consecutive clock cycles.

Top module: `pcm_pack_fifo`

## Requirements
- R1: While reset is asserted and after it is released, the FIFO is empty, `fifo_level` is 0, `fifo_rdata` is 0, `irq_status` is 0 and `irq` is low.
- R2: With packing off and `cfg_mode` 00 (left) or 01 (right), each sample strobe pushes one word: the selected channel's sample, sign-extended to 32 bits.
- R3: With packing on in a mono mode, the first strobe pushes nothing. The second strobe pushes one word with the newer sample in bits [31:16] and the older sample in bits [15:0].
- R4: With packing on and `cfg_mode` 10 or 11 (stereo), each strobe pushes one word. With `cfg_swap` low it is {left, right} (left in [31:16]). With `cfg_swap` high it is {right, left}.
- R5: With packing off in stereo, each strobe pushes two sign-extended words on consecutive cycles. The left word comes first when `cfg_swap` is low and the right word comes first when it is high.
- R6: Words leave in the order they entered. `fifo_rdata` shows the head word, `fifo_pop` removes it, and `fifo_level` gives the number of words held, at most DEPTH (16).
- R7: A `fifo_flush` pulse empties the FIFO, discards any half-collected mono pair or pending second stereo word, and drops any push or pop in that cycle.
- R8: A push to a full FIFO with no pop in the same cycle is dropped, and status bit 1 (overflow) is set.
- R9: A pop from an empty FIFO leaves `fifo_rdata` at 0 and sets status bit 2 (underflow).
- R10: Status bit 0 (threshold) is set one cycle after `fifo_level` becomes strictly greater than `fifo_thr`. It is not set when the two are equal.
- R11: Status bits stay set until cleared by the matching `irq_clr` bit. A set from `irq_set` or from a hardware event in the same cycle wins over a clear.
- R12: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 2 | 00 left, 01 right, 1x stereo |
| cfg_pack | input | 1 | Two samples per word when high |
| cfg_swap | input | 1 | Right before left in stereo ordering |
| smp_valid | input | 1 | New sample pair strobe |
| smp_left | input | 16 | Left channel sample |
| smp_right | input | 16 | Right channel sample |
| fifo_flush | input | 1 | Empty FIFO and pending halves |
| fifo_pop | input | 1 | Remove head word |
| fifo_rdata | output | 32 | Head word, 0 when empty |
| fifo_level | output | 5 | Words held |
| fifo_thr | input | 5 | Threshold for status bit 0 |
| irq_en | input | 3 | Per-cause enable (0 thr, 1 ovf, 2 udf) |
| irq_set | input | 3 | Force status bits set |
| irq_clr | input | 3 | Clear status bits |
| irq_status | output | 3 | Sticky status bits |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the embedded assertions check the following: the level bound, that a full FIFO stays full under a push with no pop, that a flush leaves the FIFO empty, that status bits are sticky when not cleared, and that the packer pushes nothing on the first half of a mono pair and drains a pending stereo word in one cycle. Word contents and ordering are shown only by the bench scenarios. These cover both swap settings, the sign extension of negative samples, the discard of a half pair at flush, the strict threshold comparison, and the set-over-clear priority. In those scenarios a behavioural queue model is compared with the outputs on every clock.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;
  typedef enum logic [1:0] {
    CH_LEFT       = 2'b00,
    CH_RIGHT      = 2'b01,
    CH_STEREO     = 2'b10,
    CH_STEREO_ALT = 2'b11
  } chan_mode_e;

  localparam int IRQ_THR = 0;
  localparam int IRQ_OVF = 1;
  localparam int IRQ_UDF = 2;
  localparam int IRQ_N   = 3;
endpackage

// File: rtl/pcm_sample_packer.sv
module pcm_sample_packer #(
  parameter int SMP_W = 16,
  localparam int WORD_W = 2 * SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pack,
  input  logic              swap,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  l_smp,
  input  logic [SMP_W-1:0]  r_smp,
  input  logic              flush,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  import pcm_pack_pkg::*;

  chan_mode_e       mode_e;
  logic             stereo;
  logic [SMP_W-1:0] mono_smp, first_smp, second_smp;

  logic             half_vld_q, half_vld_d, half_ld;
  logic [SMP_W-1:0] half_q;
  logic             tail_vld_q, tail_vld_d, tail_ld;
  logic [SMP_W-1:0] tail_q;

  assign mode_e     = chan_mode_e'(mode);
  assign stereo     = (mode_e == CH_STEREO) || (mode_e == CH_STEREO_ALT);
  assign mono_smp   = (mode_e == CH_RIGHT) ? r_smp : l_smp;
  assign first_smp  = swap ? r_smp : l_smp;
  assign second_smp = swap ? l_smp : r_smp;

  // next-state: a pending second stereo word always drains first
  always_comb begin
    half_vld_d = half_vld_q;
    tail_vld_d = tail_vld_q;
    half_ld    = 1'b0;
    tail_ld    = 1'b0;
    push       = 1'b0;
    push_word  = '0;
    if (tail_vld_q) begin
      push       = 1'b1;
      push_word  = {{SMP_W{tail_q[SMP_W-1]}}, tail_q};
      tail_vld_d = 1'b0;
    end else if (smp_valid) begin
      if (stereo) begin
        push = 1'b1;
        if (pack) begin
          push_word = {first_smp, second_smp};
        end else begin
          push_word  = {{SMP_W{first_smp[SMP_W-1]}}, first_smp};
          tail_vld_d = 1'b1;
          tail_ld    = 1'b1;
        end
      end else if (pack) begin
        if (half_vld_q) begin
          push       = 1'b1;
          push_word  = {mono_smp, half_q};
          half_vld_d = 1'b0;
        end else begin
          half_vld_d = 1'b1;
          half_ld    = 1'b1;
        end
      end else begin
        push      = 1'b1;
        push_word = {{SMP_W{mono_smp[SMP_W-1]}}, mono_smp};
      end
    end
    if (flush) begin
      push       = 1'b0;
      half_vld_d = 1'b0;
      tail_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_vld_q <= 1'b0;
      tail_vld_q <= 1'b0;
    end else begin
      half_vld_q <= half_vld_d;
      tail_vld_q <= tail_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (half_ld) half_q <= mono_smp;
    if (tail_ld) tail_q <= second_smp;
  end

  a_r3_first_half_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!stereo && pack && !half_vld_q && !tail_vld_q) |-> !push);
  a_r3_pair_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (!stereo && pack && smp_valid && half_vld_q && !tail_vld_q) |=> !half_vld_q);
  a_r5_tail_drains: assert property (@(posedge clk) disable iff (!rst_n)
    tail_vld_q |=> !tail_vld_q);
  a_r7_flush_drops_halves: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!half_vld_q && !tail_vld_q));
endmodule

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  input  logic              flush,
  output logic [WORD_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              ovf_evt,
  output logic              udf_evt
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rptr_q, rptr_d, wptr_q, wptr_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;
  logic              empty, full, pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);
  assign ovf_evt = push && !flush && full && !pop_ok;
  assign udf_evt = pop && empty && !flush;
  assign rdata   = empty ? '0 : mem[rptr_q];
  assign level   = cnt_q;

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (pop_ok)  rptr_d = ptr_inc(rptr_q);
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      cnt_d = cnt_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LVL_W'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  a_r8_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == LVL_W'(DEPTH)));
  a_r9_udf_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> (cnt_q <= 1));
endmodule

// File: rtl/pcm_irq_ctrl.sv
module pcm_irq_ctrl #(
  parameter int LVL_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LVL_W-1:0]               level,
  input  logic [LVL_W-1:0]               thr,
  input  logic                           ovf_evt,
  input  logic                           udf_evt,
  input  logic [pcm_pack_pkg::IRQ_N-1:0] en,
  input  logic [pcm_pack_pkg::IRQ_N-1:0] set,
  input  logic [pcm_pack_pkg::IRQ_N-1:0] clr,
  output logic [pcm_pack_pkg::IRQ_N-1:0] status,
  output logic                           irq
);
  import pcm_pack_pkg::*;

  logic [IRQ_N-1:0] hw_evt, status_q, status_d;

  always_comb begin
    hw_evt          = '0;
    hw_evt[IRQ_THR] = (level > thr);
    hw_evt[IRQ_OVF] = ovf_evt;
    hw_evt[IRQ_UDF] = udf_evt;
    status_d        = (status_q & ~clr) | hw_evt | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;
  assign irq    = |(status_q & en);

  for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr[i]) |=> status_q[i]);
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> status_q[i]);
  end
endmodule

// File: rtl/pcm_pack_fifo.sv
module pcm_pack_fifo #(
  parameter int SMP_W = 16,
  parameter int DEPTH = 16,
  localparam int WORD_W = 2 * SMP_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_pack,
  input  logic              cfg_swap,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_left,
  input  logic [SMP_W-1:0]  smp_right,
  input  logic              fifo_flush,
  input  logic              fifo_pop,
  output logic [WORD_W-1:0] fifo_rdata,
  output logic [LVL_W-1:0]  fifo_level,
  input  logic [LVL_W-1:0]  fifo_thr,
  input  logic [2:0]        irq_en,
  input  logic [2:0]        irq_set,
  input  logic [2:0]        irq_clr,
  output logic [2:0]        irq_status,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              push;
  logic [WORD_W-1:0] push_word;
  logic              ovf_evt, udf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  pcm_sample_packer #(.SMP_W(SMP_W)) u_packer (
    .clk(clk), .rst_n(core_rst_n), .mode(cfg_mode), .pack(cfg_pack),
    .swap(cfg_swap), .smp_valid(smp_valid), .l_smp(smp_left),
    .r_smp(smp_right), .flush(fifo_flush), .push(push), .push_word(push_word)
  );

  pcm_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(core_rst_n), .push(push), .wdata(push_word),
    .pop(fifo_pop), .flush(fifo_flush), .rdata(fifo_rdata),
    .level(fifo_level), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
  );

  pcm_irq_ctrl #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(core_rst_n), .level(fifo_level), .thr(fifo_thr),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt), .en(irq_en), .set(irq_set),
    .clr(irq_clr), .status(irq_status), .irq(irq)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (fifo_level == '0 && irq_status == '0 && !irq));
endmodule

// File: tb/test_pcm_pack_fifo.sv
module test_pcm_pack_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        cfg_pack, cfg_swap, smp_valid, fifo_flush, fifo_pop;
  logic [15:0] smp_left, smp_right;
  logic [31:0] fifo_rdata;
  logic [4:0]  fifo_level, fifo_thr;
  logic [2:0]  irq_en, irq_set, irq_clr, irq_status;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pcm_pack_fifo i_pcm_pack_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pack(cfg_pack),
    .cfg_swap(cfg_swap), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .fifo_flush(fifo_flush), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata), .fifo_level(fifo_level), .fifo_thr(fifo_thr),
    .irq_en(irq_en), .irq_set(irq_set), .irq_clr(irq_clr),
    .irq_status(irq_status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] mq[$];
  bit          m_half_v, m_tail_v;
  logic [15:0] m_half, m_tail;
  logic [2:0]  m_stat;

  function automatic logic [31:0] sx(input logic [15:0] s);
    return {{16{s[15]}}, s};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_half_v = 0; m_tail_v = 0; m_stat = '0;
    end else begin
      int          lvl;
      bit          thr_e, pv, pop_ok, push_ok, ovf, udf;
      logic [31:0] pw;
      logic [15:0] a, b, mono;
      lvl   = mq.size();
      thr_e = lvl > int'(fifo_thr);
      pv = 0; pw = '0;
      a    = cfg_swap ? smp_right : smp_left;
      b    = cfg_swap ? smp_left : smp_right;
      mono = cfg_mode[0] ? smp_right : smp_left;
      if (m_tail_v) begin
        pv = 1; pw = sx(m_tail); m_tail_v = 0;
      end else if (smp_valid) begin
        if (cfg_mode[1]) begin
          pv = 1;
          if (cfg_pack) pw = {a, b};
          else begin pw = sx(a); m_tail = b; m_tail_v = 1; end
        end else if (cfg_pack) begin
          if (m_half_v) begin pv = 1; pw = {mono, m_half}; m_half_v = 0; end
          else begin m_half = mono; m_half_v = 1; end
        end else begin
          pv = 1; pw = sx(mono);
        end
      end
      if (fifo_flush) begin pv = 0; m_half_v = 0; m_tail_v = 0; end
      pop_ok  = fifo_pop && lvl > 0 && !fifo_flush;
      push_ok = pv && !fifo_flush && (lvl < 16 || pop_ok);
      ovf     = pv && !fifo_flush && lvl == 16 && !pop_ok;
      udf     = fifo_pop && lvl == 0 && !fifo_flush;
      if (fifo_flush) mq.delete();
      else begin
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back(pw);
      end
      m_stat = (m_stat & ~irq_clr) | {udf, ovf, thr_e} | irq_set;
    end
  end

  // compare the model with the outputs every clock, 1 ns after the edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      chk("R6 R9 rdata vs model", fifo_rdata, (mq.size() > 0) ? mq[0] : 32'h0);
      chk("R6 level vs model", {27'h0, fifo_level}, mq.size());
      chk("R8 R10 R11 status vs model", {29'h0, irq_status}, {29'h0, m_stat});
      chk("R12 irq vs model", {31'h0, irq}, {31'h0, |(m_stat & irq_en)});
    end
  end

  task automatic sample(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk); smp_valid = 1; smp_left = l; smp_right = r;
    @(negedge clk); smp_valid = 0;
    @(negedge clk);
  endtask

  task automatic pop1();
    @(negedge clk); fifo_pop = 1;
    @(negedge clk); fifo_pop = 0;
    @(negedge clk);
  endtask

  task automatic flush1();
    @(negedge clk); fifo_flush = 1;
    @(negedge clk); fifo_flush = 0;
    @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk); irq_clr = 3'b111;
    @(negedge clk); irq_clr = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_mode = 2'b00; cfg_pack = 0; cfg_swap = 0; smp_valid = 0;
    smp_left = '0; smp_right = '0; fifo_flush = 0; fifo_pop = 0;
    fifo_thr = 5'd15; irq_en = 3'b000; irq_set = 3'b000; irq_clr = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1 level in reset", {27'h0, fifo_level}, 32'h0);
    chk("R1 status in reset", {29'h0, irq_status}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after reset", fifo_rdata, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 mono unpacked, sign extension
    sample(16'h8001, 16'h1234);
    chk("R2 left sext", fifo_rdata, 32'hFFFF8001);
    pop1();
    cfg_mode = 2'b01;
    sample(16'h8001, 16'h7FFE);
    chk("R2 right word", fifo_rdata, 32'h00007FFE);
    pop1();

    // R3 mono packed
    cfg_mode = 2'b00; cfg_pack = 1;
    sample(16'h1111, 16'h9999);
    chk("R3 no push on first half", {27'h0, fifo_level}, 32'h0);
    sample(16'h2222, 16'h9999);
    chk("R3 newer high older low", fifo_rdata, 32'h22221111);
    pop1();
    cfg_mode = 2'b01;
    sample(16'h0001, 16'hA0A0);
    sample(16'h0001, 16'hB0B0);
    chk("R3 right pair", fifo_rdata, 32'hB0B0A0A0);
    pop1();

    // R4 stereo packed, both swap settings
    cfg_mode = 2'b10; cfg_swap = 0;
    sample(16'hAAAA, 16'h5555);
    chk("R4 left first", fifo_rdata, 32'hAAAA5555);
    pop1();
    cfg_mode = 2'b11; cfg_swap = 1;
    sample(16'hAAAA, 16'h5555);
    chk("R4 swapped", fifo_rdata, 32'h5555AAAA);
    pop1();

    // R5 stereo unpacked
    cfg_pack = 0; cfg_mode = 2'b10; cfg_swap = 0;
    sample(16'h8000, 16'h0001);
    chk("R5 two words", {27'h0, fifo_level}, 32'h2);
    chk("R5 left word first", fifo_rdata, 32'hFFFF8000);
    pop1();
    chk("R5 right word second", fifo_rdata, 32'h00000001);
    pop1();
    cfg_swap = 1;
    sample(16'h8000, 16'h0001);
    chk("R5 swapped right first", fifo_rdata, 32'h00000001);
    pop1();
    chk("R6 fifo order", fifo_rdata, 32'hFFFF8000);
    pop1();

    // R7 flush discards pending half
    cfg_mode = 2'b00; cfg_pack = 1; cfg_swap = 0;
    sample(16'h0AAA, 16'h0);
    flush1();
    sample(16'h0BBB, 16'h0);
    chk("R7 half discarded", {27'h0, fifo_level}, 32'h0);
    sample(16'h0CCC, 16'h0);
    chk("R7 fresh pair", fifo_rdata, 32'h0CCC0BBB);
    flush1();
    chk("R7 flush empties", {27'h0, fifo_level}, 32'h0);

    // R10 strict threshold
    clr_all();
    cfg_pack = 0; fifo_thr = 5'd3;
    for (int i = 0; i < 3; i++) sample(16'(i + 1), 16'h0);
    chk("R10 equal not set", {31'h0, irq_status[0]}, 32'h0);
    sample(16'h0004, 16'h0);
    chk("R10 above sets", {31'h0, irq_status[0]}, 32'h1);

    // R12 irq gating
    chk("R12 masked", {31'h0, irq}, 32'h0);
    irq_en = 3'b001;
    @(negedge clk);
    chk("R12 enabled", {31'h0, irq}, 32'h1);

    // R8 overflow
    fifo_thr = 5'd31;
    for (int i = 0; i < 12; i++) sample(16'(16'h100 + i), 16'h0);
    chk("R8 full level", {27'h0, fifo_level}, 32'd16);
    chk("R8 no ovf yet", {31'h0, irq_status[1]}, 32'h0);
    sample(16'h7777, 16'h0);
    chk("R8 ovf set", {31'h0, irq_status[1]}, 32'h1);
    chk("R8 level held", {27'h0, fifo_level}, 32'd16);
    chk("R6 head kept", fifo_rdata, 32'h00000001);

    // R9 underflow
    flush1();
    clr_all();
    @(negedge clk); fifo_pop = 1;
    #0.5;
    chk("R9 empty reads zero", fifo_rdata, 32'h0);
    @(negedge clk); fifo_pop = 0;
    chk("R9 udf set", {31'h0, irq_status[2]}, 32'h1);

    // R11 clear, set, and set-over-clear
    @(negedge clk); irq_clr = 3'b100;
    @(negedge clk); irq_clr = 3'b000;
    chk("R11 clear", {31'h0, irq_status[2]}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 stays clear", {31'h0, irq_status[2]}, 32'h0);
    @(negedge clk); irq_set = 3'b010; irq_clr = 3'b010;
    @(negedge clk); irq_set = 3'b000; irq_clr = 3'b000;
    chk("R11 set wins", {31'h0, irq_status[1]}, 32'h1);
    irq_en = 3'b010;
    @(negedge clk);
    chk("R12 ovf enabled", {31'h0, irq}, 32'h1);
    clr_all();
    chk("R12 cleared", {31'h0, irq}, 32'h0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule